// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block sits on the host side of a serial flash and turns a single request into the full chain of SPI transactions that a program, sector-erase, bulk-erase or status-write operation needs. Each accepted request first unlocks the device with a write-enable transaction. The operation itself is then sent. The sequencer then reads the status register again and again until the busy flag clears. Completion is therefore found by watching the device, not by waiting out a fixed worst-case delay.

Requests arrive on a valid/ready port. Program data is pulled one byte at a time through a pop strobe, so the block holds no page buffer. A per-operation cycle ceiling turns a device that never finishes into a timeout pulse. Chip select is kept high for a minimum number of system clocks between any two transactions. SCK is derived from the system clock through a run-time divisor and idles low (SPI mode 0).

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, cmd_ready is 1, and done and timeout are 0.
- R2: Every accepted request starts with a one-byte write-enable transaction, 0x06, in its own chip-select window.
- R3: The operation frame depends on cmd_op (0 program, 1 sector erase, 2 bulk erase, 3 status write). Program is 0x02, then three address bytes with the most significant first, then the data. Sector erase is 0xD8 followed by the three address bytes. Bulk erase is 0xC7 alone. Status write is 0x01 followed by cmd_addr[7:0].
- R4: A program frame carries cmd_len_m1+1 data bytes, clipped so that it never passes the end of the 256-byte page that holds cmd_addr. Each data byte is taken from dat_in in the cycle where dat_pop is 1, with exactly one pop per byte.
- R5: After the operation frame, the block sends status-read frames of 0x05 plus one dummy byte 0x00. It repeats them while bit 0 of the returned status byte is 1 and ignores all other status bits. When a read returns bit 0 = 0, done pulses for exactly one cycle.
- R6: When a status read returns bit 0 = 1, the block checks how many cycles have passed since the operation frame ended. If that count has reached the limit for the operation, timeout pulses for one cycle and the block returns to idle without sending another poll.
- R7: cs_n stays high for at least CS_GAP_CYC system cycles before every falling edge, both inside a request and between requests.
- R8: SPI mode 0 is used. sck is 0 whenever cs_n is 1. Bytes are shifted most significant bit first. miso is sampled at the rising edge of sck. Every high phase of sck lasts max(sck_div,1) system cycles.
- R9: cmd_ready is 1 only when the block is idle. A request presented while an operation runs is ignored and changes no frame.
- R10: done and timeout are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted this cycle when valid is high |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 24 | Flash address; status value in bits 7:0 for a status write |
| cmd_len_m1 | input | 8 | Program byte count minus one |
| dat_in | input | 8 | Program data byte |
| dat_pop | output | 1 | dat_in consumed this cycle |
| sck_div | input | 8 | SCK half-period in system cycles (0 acts as 1) |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | Operation completed (one-cycle pulse) |
| timeout | output | 1 | Busy limit exceeded (one-cycle pulse) |

## Verification
Programs are run with a short run in the middle of a page, with a run that overflows the page end and must be clipped, and with a full 256-byte page. Together these separate correct counting from wrap or overrun. The erase and status-write frames are checked against device busy periods of zero and of several polls, which shows whether polling stops on bit 0 alone. Those runs use a status byte whose other bits are set. A device that never becomes ready shows whether the timeout fires near its ceiling. A request held during a busy operation shows that it cannot inject a frame. Divisors of 0, 1, 2 and 3 show that the SCK phase widths follow the input.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_BERASE = 2'd2,
        OP_WRSTAT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_WEN  = 2'd0,
        K_MAIN = 2'd1,
        K_POLL = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_GAP  = 2'd1,
        S_XFER = 2'd2
    } state_e;

    localparam logic [7:0] OPC_WEN    = 8'h06;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_BERASE = 8'hC7;
    localparam logic [7:0] OPC_WRSTAT = 8'h01;
    localparam logic [7:0] OPC_RDSTAT = 8'h05;
    localparam int         PAGE_BYTES = 256;
    localparam int         HDR_BYTES  = 4;

    typedef struct packed {
        op_e         op;
        logic [23:0] addr;
        logic [8:0]  ndata;
    } job_t;

    function automatic logic [8:0] clip_count(input logic [7:0] lo, input logic [7:0] len_m1);
        logic [8:0] room;
        logic [8:0] want;
        room = 9'(PAGE_BYTES) - {1'b0, lo};
        want = {1'b0, len_m1} + 9'd1;
        return (want < room) ? want : room;
    endfunction

    function automatic logic [8:0] frame_len(input kind_e k, input job_t j);
        logic [8:0] n;
        case (k)
            K_WEN:  n = 9'd1;
            K_POLL: n = 9'd2;
            default: begin
                case (j.op)
                    OP_PROG:   n = 9'(HDR_BYTES) + j.ndata;
                    OP_SERASE: n = 9'(HDR_BYTES);
                    OP_BERASE: n = 9'd1;
                    default:   n = 9'd2;
                endcase
            end
        endcase
        return n;
    endfunction

    function automatic logic [7:0] main_opcode(input op_e op);
        case (op)
            OP_PROG:   return OPC_PROG;
            OP_SERASE: return OPC_SERASE;
            OP_BERASE: return OPC_BERASE;
            default:   return OPC_WRSTAT;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(input kind_e k, input job_t j,
                                              input logic [8:0] idx, input logic [7:0] data);
        logic [7:0] b;
        case (k)
            K_WEN:  b = OPC_WEN;
            K_POLL: b = (idx == 9'd0) ? OPC_RDSTAT : 8'h00;
            default: begin
                if (idx == 9'd0)                b = main_opcode(j.op);
                else if (j.op == OP_WRSTAT)     b = j.addr[7:0];
                else if (idx == 9'd1)           b = j.addr[23:16];
                else if (idx == 9'd2)           b = j.addr[15:8];
                else if (idx == 9'd3)           b = j.addr[7:0];
                else                            b = data;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx
);
    logic             active;
    logic             phase_hi;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sr;
    logic [DIV_W-1:0] eff_div;

    assign eff_div = (div == '0) ? DIV_W'(1) : div;
    assign sck     = phase_hi;
    assign mosi    = sr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            cnt      <= '0;
            bitn     <= '0;
            sr       <= '0;
            rx       <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    phase_hi <= 1'b0;
                    cnt      <= '0;
                    bitn     <= '0;
                    sr       <= tx;
                end
            end else if (cnt == eff_div - DIV_W'(1)) begin
                cnt <= '0;
                if (!phase_hi) begin
                    phase_hi <= 1'b1;
                    rx       <= {rx[6:0], miso};
                end else begin
                    phase_hi <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sr   <= {sr[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    // R8: a byte is requested only when the shifter is free
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
    // R8: a byte ends on a falling SCK edge
    assert_done_after_high_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase_hi) && !phase_hi));
endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
    parameter int GAP = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic gap_ok
);
    localparam int GW = $clog2(GAP + 2);
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (!cs_n)            cnt <= '0;
        else if (cnt < GW'(GAP))   cnt <= cnt + GW'(1);
    end

    assign gap_ok = (cnt >= GW'(GAP));

    // R7: selection always restarts the deselect window
    assert_gap_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (GAP > 0)) |=> !gap_ok);
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog
    import flash_seq_pkg::*;
#(
    parameter int unsigned TO_PROG_CYC   = 500_000,
    parameter int unsigned TO_SERASE_CYC = 300_000_000,
    parameter int unsigned TO_BERASE_CYC = 600_000_000,
    parameter int unsigned TO_WRSTAT_CYC = 1_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  op_e  op,
    output logic expired
);
    localparam int CW = 32;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        case (op)
            OP_PROG:   limit = CW'(TO_PROG_CYC);
            OP_SERASE: limit = CW'(TO_SERASE_CYC);
            OP_BERASE: limit = CW'(TO_BERASE_CYC);
            default:   limit = CW'(TO_WRSTAT_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear)      cnt <= '0;
        else if (cnt != '1)    cnt <= cnt + CW'(1);
    end

    assign expired = (cnt >= limit);

    // R6: once the ceiling is reached it stays reached until the next operation
    assert_expired_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (expired && !clear && $stable(op)) |=> expired);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          CS_GAP_CYC    = 10,
    parameter int          DIV_W         = 8,
    parameter int unsigned TO_PROG_CYC   = 500_000,
    parameter int unsigned TO_SERASE_CYC = 300_000_000,
    parameter int unsigned TO_BERASE_CYC = 600_000_000,
    parameter int unsigned TO_WRSTAT_CYC = 1_500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [23:0]      cmd_addr,
    input  logic [7:0]       cmd_len_m1,
    input  logic [7:0]       dat_in,
    output logic             dat_pop,
    input  logic [DIV_W-1:0] sck_div,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             done,
    output logic             timeout
);
    state_e     state;
    kind_e      kind;
    job_t       job;
    logic [8:0] byte_idx;
    logic [8:0] byte_total;
    logic       cs_q;
    logic       done_q;
    logic       tmo_q;

    logic       gap_ok;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       sh_start;
    logic [8:0] tx_idx;
    logic [7:0] tx_byte;
    logic       last_byte;
    logic       wd_clear;
    logic       wd_expired;

    assign last_byte = (byte_idx == byte_total - 9'd1);
    assign sh_start  = ((state == S_GAP) && gap_ok) ||
                       ((state == S_XFER) && sh_done && !last_byte);
    assign tx_idx    = (state == S_GAP) ? 9'd0 : byte_idx + 9'd1;
    assign tx_byte   = frame_byte(kind, job, tx_idx, dat_in);
    assign dat_pop   = sh_start && (kind == K_MAIN) && (job.op == OP_PROG) &&
                       (tx_idx >= 9'(HDR_BYTES));
    assign wd_clear  = (state == S_XFER) && sh_done && last_byte && (kind == K_MAIN);

    assign cmd_ready = (state == S_IDLE);
    assign cs_n      = cs_q;
    assign done      = done_q;
    assign timeout   = tmo_q;

    spi_byte_shift #(.DIV_W(DIV_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .div   (sck_div),
        .start (sh_start),
        .tx    (tx_byte),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    cs_gap_timer #(.GAP(CS_GAP_CYC)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_q),
        .gap_ok (gap_ok)
    );

    poll_watchdog #(
        .TO_PROG_CYC   (TO_PROG_CYC),
        .TO_SERASE_CYC (TO_SERASE_CYC),
        .TO_BERASE_CYC (TO_BERASE_CYC),
        .TO_WRSTAT_CYC (TO_WRSTAT_CYC)
    ) u_wd (
        .clk     (clk),
        .rst     (rst),
        .clear   (wd_clear),
        .op      (job.op),
        .expired (wd_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            kind       <= K_WEN;
            job        <= '0;
            byte_idx   <= '0;
            byte_total <= 9'd1;
            cs_q       <= 1'b1;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        job.op    <= op_e'(cmd_op);
                        job.addr  <= cmd_addr;
                        job.ndata <= clip_count(cmd_addr[7:0], cmd_len_m1);
                        kind      <= K_WEN;
                        state     <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (gap_ok) begin
                        cs_q       <= 1'b0;
                        byte_idx   <= '0;
                        byte_total <= frame_len(kind, job);
                        state      <= S_XFER;
                    end
                end
                S_XFER: begin
                    if (sh_done) begin
                        if (!last_byte) begin
                            byte_idx <= byte_idx + 9'd1;
                        end else begin
                            cs_q <= 1'b1;
                            case (kind)
                                K_WEN: begin
                                    kind  <= K_MAIN;
                                    state <= S_GAP;
                                end
                                K_MAIN: begin
                                    kind  <= K_POLL;
                                    state <= S_GAP;
                                end
                                default: begin
                                    if (!sh_rx[0]) begin
                                        done_q <= 1'b1;
                                        state  <= S_IDLE;
                                    end else if (wd_expired) begin
                                        tmo_q <= 1'b1;
                                        state <= S_IDLE;
                                    end else begin
                                        state <= S_GAP;
                                    end
                                end
                            endcase
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R7: selection only after the deselect window has run out
    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_q) |-> $past(gap_ok));
    // R8: clock idles low while deselected
    assert_sck_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cs_q |-> !sck);
    // R9: no request accepted while a transaction is open
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_q |-> !cmd_ready);
    // R10: outcomes are exclusive
    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done_q && tmo_q));
    // R4: data is pulled only inside an open program frame
    assert_pop_selected_R4: assert property (@(posedge clk) disable iff (rst)
        dat_pop |-> !cs_q);
    // R5: done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 5;
    localparam int TO_PP      = 20000;
    localparam int TO_SE      = 3000;
    localparam int TO_BE      = 6000;
    localparam int TO_WS      = 1500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0] cmd_len_m1 = '0;
    logic [7:0] dat_in;
    logic       dat_pop;
    logic [7:0] sck_div = 8'd2;
    logic       sck, cs_n, mosi, done, timeout;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dat_idx = 0;
    bit finished = 0;

    // flash model state
    logic [7:0] cur_frame[$];
    logic [7:0] obs_b[$];
    int         obs_len[$];
    logic [7:0] exp_b[$];
    int         exp_len[$];
    logic [7:0] shin = '0;
    int         bitc = 0;
    logic [7:0] miso_sr = '0;
    int         busy_left = 0;
    int         t_main_end = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] dat_fn(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign dat_in = dat_fn(dat_idx);

    flash_cmd_seq #(
        .CS_GAP_CYC(GAP), .DIV_W(8),
        .TO_PROG_CYC(TO_PP), .TO_SERASE_CYC(TO_SE),
        .TO_BERASE_CYC(TO_BE), .TO_WRSTAT_CYC(TO_WS)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len_m1(cmd_len_m1),
        .dat_in(dat_in), .dat_pop(dat_pop), .sck_div(sck_div), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .miso(miso), .done(done), .timeout(timeout)
    );

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dat_pop) dat_idx <= dat_idx + 1;
    end

    // behavioural flash: capture MOSI on rising SCK, drive MISO on falling SCK
    always @(negedge cs_n) begin
        cur_frame.delete();
        bitc = 0;
    end
    always @(posedge sck) begin
        if (!cs_n) begin
            shin = {shin[6:0], mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                cur_frame.push_back(shin);
                if (cur_frame.size() == 1 && shin == 8'h05)
                    miso_sr = (busy_left > 0) ? 8'hC3 : 8'hC2;
            end
        end
    end
    always @(negedge sck) begin
        if (!cs_n) begin
            miso    = miso_sr[7];
            miso_sr = {miso_sr[6:0], 1'b0};
        end
    end
    always @(posedge cs_n) begin
        if (cur_frame.size() > 0) begin
            obs_len.push_back(cur_frame.size());
            foreach (cur_frame[i]) obs_b.push_back(cur_frame[i]);
            if (cur_frame[0] == 8'h05) begin
                if (busy_left > 0) busy_left--;
            end else if (cur_frame[0] != 8'h06) begin
                t_main_end = cyc;
            end
            cur_frame.delete();
        end
    end

    // per-clock protocol monitors
    int  hi_run = 0;
    int  cs_hi_run = 0;
    logic sck_prev = 1'b0;
    logic cs_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n && sck) check(0, "R8 sck high while deselected", 1, 0);
            if (!cs_n && cmd_ready) check(0, "R9 ready while selected", 1, 0);
            if (done && timeout) check(0, "R10 done with timeout", 1, 0);
            if (sck) hi_run++;
            if (sck_prev && !sck) begin
                check(hi_run == ((sck_div == 0) ? 1 : int'(sck_div)),
                      "R8 sck high width", hi_run, (sck_div == 0) ? 1 : int'(sck_div));
                hi_run = 0;
            end
            if (cs_n) cs_hi_run++;
            if (cs_prev && !cs_n) begin
                check(cs_hi_run >= GAP, "R7 cs high gap", cs_hi_run, GAP);
                cs_hi_run = 0;
            end
            sck_prev = sck;
            cs_prev  = cs_n;
        end
    end

    task automatic add_frame(input logic [7:0] b[$]);
        exp_len.push_back(b.size());
        foreach (b[i]) exp_b.push_back(b[i]);
    endtask

    task automatic clear_frames();
        obs_b.delete(); obs_len.delete(); exp_b.delete(); exp_len.delete();
        dat_idx = 0;
    endtask

    // prefix_only: compare expected frames, then require any extra frames to be polls
    task automatic cmp_frames(input string rq, input bit prefix_only);
        int oo = 0;
        int eo = 0;
        int n;
        if (!prefix_only)
            check(obs_len.size() == exp_len.size(), {rq, " frame count"}, obs_len.size(), exp_len.size());
        n = (obs_len.size() < exp_len.size()) ? obs_len.size() : exp_len.size();
        for (int f = 0; f < n; f++) begin
            bit ok = (obs_len[f] == exp_len[f]);
            int bad_a = 0;
            int bad_e = 0;
            if (ok) begin
                for (int k = 0; k < exp_len[f]; k++)
                    if (obs_b[oo+k] !== exp_b[eo+k]) begin
                        if (ok) begin bad_a = obs_b[oo+k]; bad_e = exp_b[eo+k]; end
                        ok = 0;
                    end
            end else begin
                bad_a = obs_len[f]; bad_e = exp_len[f];
            end
            check(ok, $sformatf("%s frame %0d", rq, f), bad_a, bad_e);
            oo += obs_len[f];
            eo += exp_len[f];
        end
        if (prefix_only) begin
            check(obs_len.size() > exp_len.size(), {rq, " polls seen"}, obs_len.size(), exp_len.size() + 1);
            for (int f = n; f < obs_len.size(); f++) begin
                check(obs_len[f] == 2 && obs_b[oo] == 8'h05 && obs_b[oo+1] == 8'h00,
                      {rq, " poll frame"}, obs_b[oo], 5);
                oo += obs_len[f];
            end
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [23:0] a, input logic [7:0] lm1);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len_m1 = lm1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // returns 1 for done, 2 for timeout, 0 for none
    task automatic wait_end(output int how, output int when);
        how = 0; when = 0;
        for (int i = 0; i < 60000 && how == 0; i++) begin
            @(negedge clk);
            if (done) begin how = 1; when = cyc; end
            else if (timeout) begin how = 2; when = cyc; end
        end
        @(negedge clk);
        check(!done && !timeout, "R5 R6 outcome pulse one cycle", done | timeout, 0);
        repeat (GAP + 4) @(negedge clk);
    endtask

    task automatic poll_frames(input int n);
        for (int i = 0; i < n; i++) add_frame('{8'h05, 8'h00});
    endtask

    task automatic run_prog(input logic [23:0] a, input logic [7:0] lm1, input int busy, input string rq);
        int how, when, n;
        logic [7:0] fr[$];
        clear_frames();
        busy_left = busy;
        n = 256 - int'(a[7:0]);
        if (int'(lm1) + 1 < n) n = int'(lm1) + 1;
        add_frame('{8'h06});
        fr = '{8'h02, a[23:16], a[15:8], a[7:0]};
        for (int k = 0; k < n; k++) fr.push_back(dat_fn(k));
        add_frame(fr);
        poll_frames(busy + 1);
        issue(2'd0, a, lm1);
        wait_end(how, when);
        check(how == 1, {rq, " done"}, how, 1);
        check(dat_idx == n, {rq, " R4 pop count"}, dat_idx, n);
        cmp_frames(rq, 0);
    endtask

    int how, when;
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        check(sck == 1'b0, "R1 sck", sck, 0);
        check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        check(done == 1'b0 && timeout == 1'b0, "R1 outcome", done | timeout, 0);

        // R2 R3 R4 R5: short program inside a page, two busy polls
        sck_div = 8'd2;
        run_prog(24'h000010, 8'd3, 2, "R2 R3 R4 R5 prog short");

        // R4 clipped at page end: 10 requested, 4 room
        sck_div = 8'd1;
        run_prog(24'h0001FC, 8'd9, 0, "R4 prog clipped");

        // R4 full page, divisor 0 acts as 1 (R8)
        sck_div = 8'd0;
        run_prog(24'h000300, 8'd255, 1, "R4 R8 prog full page");

        // R3 R5 sector erase, ready at first poll
        sck_div = 8'd3;
        clear_frames(); busy_left = 0;
        add_frame('{8'h06}); add_frame('{8'hD8, 8'h01, 8'h23, 8'h45}); poll_frames(1);
        issue(2'd1, 24'h012345, 8'd0);
        wait_end(how, when);
        check(how == 1, "R3 R5 sector erase done", how, 1);
        cmp_frames("R3 sector erase", 0);

        // R3 R9 bulk erase with three busy polls and a request held while busy
        sck_div = 8'd2;
        clear_frames(); busy_left = 3;
        add_frame('{8'h06}); add_frame('{8'hC7}); poll_frames(4);
        issue(2'd2, 24'hABCDEF, 8'd0);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 24'h777777;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (cmd_ready) check(0, "R9 ready during operation", 1, 0);
        end
        check(cmd_ready == 1'b0, "R9 busy not ready", cmd_ready, 0);
        cmd_valid = 1'b0;
        wait_end(how, when);
        check(how == 1, "R3 R9 bulk erase done", how, 1);
        cmp_frames("R3 R9 bulk erase", 0);

        // R3 status write
        sck_div = 8'd1;
        clear_frames(); busy_left = 1;
        add_frame('{8'h06}); add_frame('{8'h01, 8'h9C}); poll_frames(2);
        issue(2'd3, 24'h00009C, 8'd0);
        wait_end(how, when);
        check(how == 1, "R3 status write done", how, 1);
        cmp_frames("R3 status write", 0);

        // R6 device never ready: timeout near the status-write ceiling
        sck_div = 8'd1;
        clear_frames(); busy_left = 1000000;
        add_frame('{8'h06}); add_frame('{8'h01, 8'h5A});
        issue(2'd3, 24'h00005A, 8'd0);
        wait_end(how, when);
        check(how == 2, "R6 timeout raised", how, 2);
        check(when - t_main_end >= TO_WS - 2, "R6 timeout not early", when - t_main_end, TO_WS);
        check(when - t_main_end <= TO_WS + 150, "R6 timeout not late", when - t_main_end, TO_WS);
        cmp_frames("R6 timeout", 1);
        check(cmd_ready == 1'b1, "R6 idle after timeout", cmd_ready, 1);
        busy_left = 0;

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule